// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block models a legacy eight-input priority interrupt controller. Software reaches it through two byte-wide I/O addresses: a command port (address 0) and a data port (address 1). After reset, software programs it with a four-word initialization sequence. It then uses three kinds of operation word:

- a mask word;
- an end-of-interrupt / priority word;
- a read-select / poll word.

The controller keeps three 8-bit registers: request, in-service and mask. It resolves the highest-priority eligible request under a rotatable priority order and drives a single interrupt line towards the processor.

A separate input conditioner feeds the request register. It gives a per-pin set strobe and a per-pin "still active" flag. The flag stops an acknowledge from clearing a request whose source still holds its line. When the processor takes the interrupt it pulses the acknowledge input. In that same cycle the block presents an 8-bit vector, which is the programmed base plus the winning pin. The block then updates its request, in-service and priority state.

Bad programming words and bad accesses raise a sticky error flag. A dedicated clear input drops the flag. Cascading, polled reads and the special mask and buffered modes are not modelled.

Top module: `prio_intc`

## Requirements
- R1: After reset `intr` and `err` are 0, the request, in-service and mask registers read 0, and a command-port read returns the request register.
- R2: A command write with bit 4 set starts initialization and returns the mask, the read select and the priority order to their reset values. The next three data writes are the base word, an ignored word, and the mode word. In the base word, bits 7:3 become the vector base. After an accepted mode word the controller is ready and an acknowledge returns base*8 + pin.
- R3: These errors set `err`, and `err` stays set until an `errClr` pulse:
  - a start word with bit 1 set (single mode);
  - a start word with bit 0 clear (mode word not requested);
  - a mode word with bit 0 clear (not processor mode).
  A bad start word leaves the data port idle. A bad mode word leaves the controller not ready.
- R4: `reqSet` pulses are ignored while the controller is not ready.
- R5: Once ready, a data write loads the mask register and a data read returns it. A masked pin's request still shows in the request register but does not raise `intr`.
- R6: After initialization, pin 0 has the highest priority and pin 7 the lowest. A request is eligible only if it is unmasked and strictly higher in priority than every in-service pin. `intr` is 1 exactly when an eligible request exists.
- R7: An acknowledge with nothing eligible returns base*8 + 7 and is treated as an acknowledge of pin 7.
- R8: An acknowledge clears the winning pin's request bit only if that pin's `reqHeld` flag is 0. Without auto-EOI it sets the pin's in-service bit.
- R9: A priority word with bit 5 set ends an interrupt.
  - With bit 6 clear, the highest-priority in-service bit is cleared.
  - With bit 6 set, the in-service bit named by bits 2:0 is cleared.
- R10: Bit 7 of a priority word latches rotate mode. While rotate is on, a cleared end-of-interrupt pin becomes the lowest-priority pin. A word with bit 6 set, bit 5 clear and bit 7 set makes pin bits 2:0 the lowest priority. The pin after the lowest-priority pin, counting modulo 8, has the highest priority.
- R11: When mode-word bit 1 is set (auto-EOI), an acknowledge does not set an in-service bit. If rotate is on, the acknowledged pin becomes the lowest-priority pin.
- R12: A command write with bit 4 clear and bit 3 set is a select word. If bit 1 is set, bit 0 selects what command-port reads return: the in-service register (1) or the request register (0). If bit 1 is clear, the selection is kept.
- R13: Select-word bit 2 latches poll mode. While poll mode is latched, any read returns 0 and sets `err`.
- R14: An access with `busWide` set has no effect and sets `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busRdEn | input | 1 | Read strobe for one cycle |
| busAddr | input | 1 | 0 = command port, 1 = data port |
| busWide | input | 1 | Access is wider than one byte |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle of `busRdEn` |
| reqSet | input | 8 | Per-pin request set strobe |
| reqHeld | input | 8 | Per-pin "input still active" flag |
| ackEn | input | 1 | Interrupt acknowledge strobe |
| ackVector | output | 8 | Vector returned during `ackEn` |
| intr | output | 1 | Interrupt request to the processor |
| errClr | input | 1 | Clears the sticky error flag |
| err | output | 1 | Sticky error flag |

## Verification
A wrong priority pointer or a stale in-service bit shows up on the first acknowledge that follows: the returned vector names the wrong pin. The same fault also shows on `intr` in the cycle after the disturbing write, because an eligible request appears to be held back, or a blocked one comes through. A lost or falsely kept request bit appears on the next command-port read with the request register selected. It also appears as an `intr` that stays high, or never rises, after the end-of-interrupt that should release it. Wrong sequencing of the initialization words shows as a wrong vector base or a mask that does not read back. The acknowledge and read sequences are therefore chosen so that fixed and rotated priority orders give different pins.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_BASE = 2'd1,
    STEP_SKIP = 2'd2,
    STEP_MODE = 2'd3
  } initStep_t;

  typedef struct packed {
    logic icw1;
    logic icw2;
    logic icw4;
    logic maskWr;
    logic ocw2;
    logic ocw3;
    logic ack;
  } intcStrobe_t;

  // Command-word bit positions the decoder depends on
  localparam int B_INIT   = 4;
  localparam int B_SELECT = 3;
  localparam int B_SNGL   = 1;
  localparam int B_NEED4  = 0;
  localparam int B_CPU    = 0;
  localparam int B_AUTO   = 1;
  localparam int B_ROT    = 7;
  localparam int B_SPEC   = 6;
  localparam int B_EOI    = 5;
  localparam int B_POLL   = 2;
  localparam int B_RDSEL  = 1;
  localparam int B_RDISR  = 0;

endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic        busAddr,
  input  logic        busWide,
  input  logic [7:0]  busWdata,
  input  logic        pollOn,
  input  logic        ackEn,
  input  logic        errClr,
  output intcStrobe_t strobe,
  output logic        ready,
  output logic        err
);

  initStep_t step;
  logic wrOk, rdOk, cmdWr, datWr, icw4Try, icw1Bad, errSet;
  logic unusedBits;

  assign unusedBits = ^{busWdata[7:5], busWdata[2]};

  assign wrOk  = busWrEn && !busWide;
  assign rdOk  = busRdEn && !busWide;
  assign cmdWr = wrOk && !busAddr;
  assign datWr = wrOk && busAddr;

  always_comb begin
    strobe        = '0;
    strobe.icw1   = cmdWr && busWdata[B_INIT];
    strobe.ocw3   = cmdWr && !busWdata[B_INIT] && ready && busWdata[B_SELECT];
    strobe.ocw2   = cmdWr && !busWdata[B_INIT] && ready && !busWdata[B_SELECT];
    strobe.maskWr = datWr && ready;
    strobe.icw2   = datWr && !ready && (step == STEP_BASE);
    strobe.icw4   = datWr && !ready && (step == STEP_MODE) && busWdata[B_CPU];
    strobe.ack    = ackEn;
  end

  assign icw4Try = datWr && !ready && (step == STEP_MODE);
  assign icw1Bad = strobe.icw1 && (busWdata[B_SNGL] || !busWdata[B_NEED4]);
  assign errSet  = icw1Bad
                || (icw4Try && !busWdata[B_CPU])
                || (rdOk && pollOn)
                || ((busWrEn || busRdEn) && busWide);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step  <= STEP_IDLE;
      ready <= 1'b0;
      err   <= 1'b0;
    end else begin
      if (errSet)      err <= 1'b1;
      else if (errClr) err <= 1'b0;

      if (strobe.icw1) begin
        ready <= 1'b0;
        step  <= icw1Bad ? STEP_IDLE : STEP_BASE;
      end else if (strobe.icw2) begin
        step <= STEP_SKIP;
      end else if (datWr && !ready && step == STEP_SKIP) begin
        step <= STEP_MODE;
      end else if (strobe.icw4) begin
        ready <= 1'b1;
        step  <= STEP_IDLE;
      end
    end
  end

endmodule

// File: rtl/intc_dp.sv
module intc_dp
  import intc_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  intcStrobe_t     strobe,
  input  logic [7:0]      busWdata,
  input  logic            busAddr,
  input  logic            ready,
  input  logic [NPIN-1:0] reqSet,
  input  logic [NPIN-1:0] reqHeld,
  output logic [NPIN-1:0] irrQ,
  output logic [NPIN-1:0] isrQ,
  output logic [NPIN-1:0] maskQ,
  output logic            aeoiQ,
  output logic            pollOn,
  output logic [7:0]      busRdata,
  output logic            intr,
  output logic [7:0]      ackVector
);

  localparam int PW = $clog2(NPIN);
  localparam int BW = 8 - PW;
  localparam logic [PW-1:0] SPUR_PIN = PW'(NPIN - 1);

  logic [PW-1:0] lowPri, reqPin, isrPin, ackPin, eoiPin, p;
  logic [BW-1:0] baseQ;
  logic          rotQ, risQ, reqHit, isrHit, blocked, eoiDo;
  logic [NPIN-1:0] irrN, isrN;
  logic [PW-1:0]   lowN;

  // Priority scan: start at the pin just above the lowest-priority pin
  always_comb begin
    reqHit  = 1'b0;
    reqPin  = SPUR_PIN;
    isrHit  = 1'b0;
    isrPin  = '0;
    blocked = 1'b0;
    p       = '0;
    for (int i = 0; i < NPIN; i++) begin
      p = lowPri + PW'(i + 1);
      if (!blocked) begin
        if (isrQ[p]) begin
          blocked = 1'b1;
          isrHit  = 1'b1;
          isrPin  = p;
        end else if (!reqHit && irrQ[p] && !maskQ[p]) begin
          reqHit = 1'b1;
          reqPin = p;
        end
      end
    end
  end

  assign ackPin    = reqHit ? reqPin : SPUR_PIN;
  assign intr      = reqHit;
  assign ackVector = {baseQ, ackPin};

  assign eoiPin = busWdata[B_SPEC] ? busWdata[PW-1:0] : isrPin;
  assign eoiDo  = strobe.ocw2 && busWdata[B_EOI] && (busWdata[B_SPEC] || isrHit);

  always_comb begin
    irrN = irrQ;
    if (strobe.ack && !reqHeld[ackPin]) irrN[ackPin] = 1'b0;
    if (ready) irrN = irrN | reqSet;

    isrN = isrQ;
    if (eoiDo) isrN[eoiPin] = 1'b0;
    if (strobe.ack && !aeoiQ) isrN[ackPin] = 1'b1;

    lowN = lowPri;
    if (strobe.icw1) lowN = SPUR_PIN;
    else if (eoiDo && busWdata[B_ROT]) lowN = eoiPin;
    else if (strobe.ocw2 && busWdata[B_SPEC] && !busWdata[B_EOI] && busWdata[B_ROT])
      lowN = busWdata[PW-1:0];
    if (strobe.ack && aeoiQ && rotQ) lowN = ackPin;
  end

  always_comb begin
    if (pollOn)       busRdata = '0;
    else if (busAddr) busRdata = maskQ;
    else if (risQ)    busRdata = isrQ;
    else              busRdata = irrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrQ   <= '0;
      isrQ   <= '0;
      maskQ  <= '0;
      lowPri <= SPUR_PIN;
      baseQ  <= '0;
      rotQ   <= 1'b0;
      aeoiQ  <= 1'b0;
      pollOn <= 1'b0;
      risQ   <= 1'b0;
    end else begin
      irrQ   <= irrN;
      isrQ   <= isrN;
      lowPri <= lowN;
      if (strobe.icw1) begin
        maskQ <= '0;
        risQ  <= 1'b0;
      end
      if (strobe.maskWr) maskQ <= busWdata;
      if (strobe.icw2)   baseQ <= busWdata[7:PW];
      if (strobe.icw4)   aeoiQ <= busWdata[B_AUTO];
      if (strobe.ocw2)   rotQ  <= busWdata[B_ROT];
      if (strobe.ocw3) begin
        pollOn <= busWdata[B_POLL];
        if (busWdata[B_RDSEL]) risQ <= busWdata[B_RDISR];
      end
    end
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busWrEn,
  input  logic            busRdEn,
  input  logic            busAddr,
  input  logic            busWide,
  input  logic [7:0]      busWdata,
  output logic [7:0]      busRdata,
  input  logic [NPIN-1:0] reqSet,
  input  logic [NPIN-1:0] reqHeld,
  input  logic            ackEn,
  output logic [7:0]      ackVector,
  output logic            intr,
  input  logic            errClr,
  output logic            err
);

  intcStrobe_t     strobe;
  logic            ready, pollOn, aeoiQ;
  logic [NPIN-1:0] irrQ, isrQ, maskQ;

  intc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWide(busWide), .busWdata(busWdata), .pollOn(pollOn),
    .ackEn(ackEn), .errClr(errClr),
    .strobe(strobe), .ready(ready), .err(err)
  );

  intc_dp #(.NPIN(NPIN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busAddr(busAddr), .ready(ready), .reqSet(reqSet), .reqHeld(reqHeld),
    .irrQ(irrQ), .isrQ(isrQ), .maskQ(maskQ), .aeoiQ(aeoiQ),
    .pollOn(pollOn), .busRdata(busRdata), .intr(intr), .ackVector(ackVector)
  );

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            busWrEn,
  input logic            busRdEn,
  input logic            busWide,
  input logic            ackEn,
  input logic [7:0]      ackVector,
  input logic            intr,
  input logic            errClr,
  input logic            err,
  input logic [NPIN-1:0] irrQ,
  input logic [NPIN-1:0] isrQ,
  input logic [NPIN-1:0] maskQ,
  input logic            aeoiQ
);

  // R3: error flag holds until cleared
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    err && !errClr |=> err);

  // R6: the interrupt line needs an unmasked pending request
  a_r6_intr_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    intr |-> ((irrQ & ~maskQ) != '0));

  // R7: nothing eligible means the spurious pin
  a_r7_spurious_pin: assert property (@(posedge clk) disable iff (!rstN)
    ackEn && !intr |-> ackVector[2:0] == 3'd7);

  // R8: a normal acknowledge leaves some pin in service
  a_r8_ack_sets_service: assert property (@(posedge clk) disable iff (!rstN)
    ackEn && !aeoiQ && !busWrEn |=> isrQ != '0);

  // R11: auto-EOI acknowledge leaves in-service untouched
  a_r11_auto_no_service: assert property (@(posedge clk) disable iff (!rstN)
    ackEn && aeoiQ && !busWrEn |=> $stable(isrQ));

  // R14: a wide access always flags an error
  a_r14_wide_flags: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn || busRdEn) && busWide |=> err);

endmodule

bind prio_intc prio_intc_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
  .busWide(busWide), .ackEn(ackEn), .ackVector(ackVector), .intr(intr),
  .errClr(errClr), .err(err), .irrQ(irrQ), .isrQ(isrQ), .maskQ(maskQ),
  .aeoiQ(aeoiQ)
);

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0, busRdEn = 1'b0, busAddr = 1'b0, busWide = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] reqSet = '0, reqHeld = '0;
  logic       ackEn = 1'b0;
  logic [7:0] ackVector;
  logic       intr;
  logic       errClr = 1'b0;
  logic       err;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  typedef struct {
    bit         isAck;
    logic [7:0] val;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2 clk = ~clk;

  prio_intc u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWide(busWide), .busWdata(busWdata),
    .busRdata(busRdata), .reqSet(reqSet), .reqHeld(reqHeld),
    .ackEn(ackEn), .ackVector(ackVector), .intr(intr),
    .errClr(errClr), .err(err)
  );

  // Monitor: sample one time unit after the falling edge
  always begin
    @(negedge clk);
    #1;
    if (busRdEn && !busWide) compareNext(1'b0, busRdata);
    if (ackEn) compareNext(1'b1, ackVector);
  end

  task automatic compareNext(input bit isAck, input logic [7:0] got);
    expItem_t e;
    nChecks++;
    if (expQ.size() == 0) begin
      nFails++;
      $display("FAIL unexpected result: actual %02h expected none", got);
    end else begin
      e = expQ.pop_front();
      if (e.isAck != isAck || got !== e.val) begin
        nFails++;
        $display("FAIL %s: actual %02h expected %02h", e.tag, got, e.val);
      end
    end
  endtask

  task automatic chk(input logic got, input logic exp, input string tag);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input bit wide = 1'b0);
    busWrEn = 1'b1; busAddr = a; busWdata = d; busWide = wide;
    @(negedge clk);
    busWrEn = 1'b0; busWide = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    expQ.push_back('{isAck: 1'b0, val: exp, tag: tag});
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic rdWide(input logic a);
    busRdEn = 1'b1; busAddr = a; busWide = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0; busWide = 1'b0;
  endtask

  task automatic ack(input logic [7:0] exp, input string tag);
    expQ.push_back('{isAck: 1'b1, val: exp, tag: tag});
    ackEn = 1'b1;
    @(negedge clk);
    ackEn = 1'b0;
  endtask

  task automatic raise(input logic [7:0] pins);
    reqSet = pins;
    @(negedge clk);
    reqSet = '0;
  endtask

  task automatic clearErr();
    errClr = 1'b1;
    @(negedge clk);
    errClr = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(intr, 1'b0, "R1 intr after reset");
    chk(err, 1'b0, "R1 err after reset");
    rd(1'b0, 8'h00, "R1 request reads 0");
    rd(1'b1, 8'h00, "R1 mask reads 0");

    // R4 requests ignored before init
    raise(8'h08);
    rd(1'b0, 8'h00, "R4 request ignored when not ready");
    chk(intr, 1'b0, "R4 intr stays low");

    // R3 bad start words
    wr(1'b0, 8'h13);
    chk(err, 1'b1, "R3 single mode rejected");
    clearErr();
    chk(err, 1'b0, "R3 err cleared");
    wr(1'b0, 8'h10);
    chk(err, 1'b1, "R3 missing mode word rejected");
    clearErr();

    // R2 / R3 init with bad mode word, then good one
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h27);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h00);
    chk(err, 1'b1, "R3 mode word without processor bit");
    raise(8'h01);
    rd(1'b0, 8'h00, "R4 request ignored after bad mode word");
    clearErr();
    wr(1'b1, 8'h01);
    chk(err, 1'b0, "R2 good mode word no error");
    rd(1'b1, 8'h00, "R2 mask cleared by init");

    // R5 masking
    wr(1'b1, 8'h04);
    raise(8'h04);
    chk(intr, 1'b0, "R5 masked pin no intr");
    rd(1'b0, 8'h04, "R5 masked request visible");
    rd(1'b1, 8'h04, "R5 mask readback");
    wr(1'b1, 8'h00);
    chk(intr, 1'b1, "R5 unmask raises intr");
    ack(8'h22, "R2 vector base plus pin");
    chk(intr, 1'b0, "R8 intr drops after ack");

    // R12 read select
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h04, "R12 in-service selected");
    wr(1'b0, 8'h08);
    rd(1'b0, 8'h04, "R12 selection retained");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h00, "R8 request cleared by ack");

    // R6 nesting
    raise(8'h20);
    chk(intr, 1'b0, "R6 lower pin blocked by service");
    raise(8'h02);
    chk(intr, 1'b1, "R6 higher pin interrupts");
    ack(8'h21, "R6 highest eligible pin");
    chk(intr, 1'b0, "R6 pin5 still blocked");

    // R9 end of interrupt
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h04, "R9 non-specific clears highest");
    chk(intr, 1'b0, "R9 pin5 blocked by pin2");
    wr(1'b0, 8'h62);
    rd(1'b0, 8'h00, "R9 specific clears named pin");
    chk(intr, 1'b1, "R9 pin5 released");

    // R8 held input keeps request
    reqHeld = 8'h20;
    ack(8'h25, "R8 ack pin5 while held");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h20, "R8 held request kept");
    chk(intr, 1'b0, "R6 pin cannot preempt itself");
    reqHeld = 8'h00;
    wr(1'b0, 8'h20);
    chk(intr, 1'b1, "R8 kept request re-raises");
    ack(8'h25, "R8 second ack pin5");
    rd(1'b0, 8'h00, "R8 released request cleared");
    wr(1'b0, 8'h20);
    chk(intr, 1'b0, "R9 idle after eoi");

    // R7 spurious
    ack(8'h27, "R7 spurious vector");
    wr(1'b0, 8'h67);

    // R10 rotation
    wr(1'b0, 8'hC3);
    raise(8'h22);
    ack(8'h25, "R10 pin5 wins when pin3 lowest");
    chk(intr, 1'b0, "R10 pin1 below pin5");
    wr(1'b0, 8'hA0);
    chk(intr, 1'b1, "R10 rotate eoi releases pin1");
    ack(8'h21, "R10 ack pin1");
    wr(1'b0, 8'hA0);
    raise(8'h05);
    ack(8'h22, "R10 pin2 above pin0 after rotate to pin1");
    chk(intr, 1'b0, "R10 pin0 blocked");
    wr(1'b0, 8'h20);
    ack(8'h20, "R10 pin0 after eoi");
    wr(1'b0, 8'h20);

    // R11 auto-EOI with rotation
    wr(1'b0, 8'h11);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h03);
    wr(1'b0, 8'h80);
    raise(8'h44);
    ack(8'h42, "R11 first ack pin2");
    chk(intr, 1'b1, "R11 pin6 still pending");
    raise(8'h02);
    ack(8'h46, "R11 rotated order picks pin6");
    ack(8'h41, "R11 then pin1");
    chk(intr, 1'b0, "R11 nothing left");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h00, "R11 no in-service bits");

    // R13 poll mode
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h00, "R13 poll read returns 0");
    chk(err, 1'b1, "R13 poll read flags error");
    clearErr();
    wr(1'b0, 8'h08);
    rd(1'b1, 8'h00, "R13 reads normal after poll off");
    chk(err, 1'b0, "R13 no error after poll off");

    // R14 wide access
    wr(1'b1, 8'hFF, 1'b1);
    chk(err, 1'b1, "R14 wide write flags error");
    rd(1'b1, 8'h00, "R14 wide write ignored");
    clearErr();
    rdWide(1'b1);
    chk(err, 1'b1, "R14 wide read flags error");

    @(negedge clk);
    if (expQ.size() != 0) begin
      nChecks++;
      nFails++;
      $display("FAIL scoreboard: actual %0d left expected 0", expQ.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

endmodule